// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reason a small low-power microcontroller may need to restart and turns them into three outputs. A stretched system reset clears the peripherals. A CPU reset is held longer, until the oscillator has settled. A power-on clear line goes to the option registers. Five requests feed it:

- power-on, which acts as an asynchronous input;
- a debounced match of the input pins against a programmed high/low pattern;
- a watchdog timeout;
- an oscillator failure;
- entry into sleep.

The block also holds the sleep-enable latch. It keeps a write-one-to-clear flag register that shows which source caused the latest reset.

Power-on is the only source that clears configuration. It resets the option registers through the clear line, and it clears the sleep-enable latch. The four other sources only drive the two reset outputs. Software can inhibit the watchdog path and the oscillator path, and it can disable the pin-pattern path. A sleep request is honoured only after software has set the sleep-enable latch.

Top module: `rst_seq`

## Requirements
- R1: Each of the watchdog, oscillator-failure, pin-pattern and sleep requests, once accepted at a clock edge, raises both `sys_rst` and `cpu_rst` right after that edge.
- R2: `sys_rst` stays high for exactly SYS_N (default 8) clock cycles after the last edge at which any request was accepted.
- R3: `cpu_rst` stays high for exactly CPU_N (default 32) clock cycles after the last accepted request, and it is high whenever `sys_rst` is high.
- R4: While `por_req` is high, the outputs are forced at once to the following values: `sys_rst`=1, `cpu_rst`=1, `opt_clr`=1, `sleep_en`=0 and `status`=5'b00001. `opt_clr` drops at the first clock edge after `por_req` falls, and the reset stretches count from that edge.
- R5: The watchdog, oscillator, pin and sleep sources never change `sleep_en` and never raise `opt_clr`.
- R6: The pins match when `pin_mask` is nonzero and every pin selected by `pin_mask` equals the corresponding bit of `pin_level`. Unselected pins are ignored. A zero mask never matches.
- R7: A pin match becomes a request only after it has been seen on DEB_N (default 4) consecutive `deb_tick` samples. A tick that sees no match restarts the count. While `pin_dis` is 1, the pin request is blocked.
- R8: A watchdog request while `wdog_inh`=1 is ignored. An oscillator-failure request while `osc_inh`=1 is ignored.
- R9: `sleep_req` starts a reset only while `sleep_en` is 1. `sleep_en_set` sets the latch from the next edge on.
- R10: The bits of `status` are: bit0 power-on, bit1 pin pattern, bit2 watchdog, bit3 oscillator, bit4 sleep. An accepted request replaces `status` with the one-hot bit of the lowest-numbered source that is active. With no request, a cycle with `stat_we`=1 clears every bit that is 1 in `stat_wdata`.
- R11: A request accepted while a stretch is running restarts both counts from their full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| pin_in | input | PINS | Input port pins |
| pin_mask | input | PINS | Option field: pins taking part in the pattern |
| pin_level | input | PINS | Option field: required level of each selected pin |
| pin_dis | input | 1 | Option bit: disables the pin-pattern reset |
| deb_tick | input | 1 | Debounce sample strobe |
| wdog_req | input | 1 | Watchdog timeout request |
| wdog_inh | input | 1 | Inhibits the watchdog path |
| osc_fail_req | input | 1 | Oscillator failure request |
| osc_inh | input | 1 | Inhibits the oscillator path |
| sleep_req | input | 1 | Sleep entry request |
| sleep_en_set | input | 1 | Sets the sleep-enable latch |
| stat_we | input | 1 | Status clear strobe |
| stat_wdata | input | 5 | Status bits to clear (write one to clear) |
| opt_clr | output | 1 | Clear line for the option registers |
| sleep_en | output | 1 | Sleep-enable latch |
| sys_rst | output | 1 | Stretched system reset |
| cpu_rst | output | 1 | Stretched CPU reset |
| status | output | 5 | Flag of the last reset source |

## Verification
The assertions check four things on every cycle:

- any accepted watchdog, oscillator or sleep request raises both resets;
- the CPU reset covers the system reset;
- the system reset never falls right after a request;
- the sleep-enable latch and the option-clear line never change outside power-on, and the status is never more than one-hot.

Some behaviours can only be shown by the bench's scenarios. These are the exact stretch lengths, the restart on a late request, the debounce count and its restart, the pattern mask and the disable bit, the source priority in the status register, and the write-one-to-clear behaviour.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int PINS  = 4,
  parameter int SYS_N = 8,
  parameter int CPU_N = 32,
  parameter int DEB_N = 4
) (
  input  logic            clk,
  input  logic            por_req,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] pin_mask,
  input  logic [PINS-1:0] pin_level,
  input  logic            pin_dis,
  input  logic            deb_tick,
  input  logic            wdog_req,
  input  logic            wdog_inh,
  input  logic            osc_fail_req,
  input  logic            osc_inh,
  input  logic            sleep_req,
  input  logic            sleep_en_set,
  input  logic            stat_we,
  input  logic [4:0]      stat_wdata,
  output logic            opt_clr,
  output logic            sleep_en,
  output logic            sys_rst,
  output logic            cpu_rst,
  output logic [4:0]      status
);
  localparam int SW = $clog2(SYS_N + 1);
  localparam int CW = $clog2(CPU_N + 1);
  localparam int DW = $clog2(DEB_N + 1);

  logic [DW-1:0] deb_cnt;
  logic [SW-1:0] sys_cnt;
  logic [CW-1:0] cpu_cnt;
  logic          pin_match, ext_req, any_src;
  logic [4:0]    src, first;

  assign pin_match = (|pin_mask) && (((pin_in ~^ pin_level) & pin_mask) == pin_mask);
  assign ext_req   = !pin_dis && (deb_cnt == DW'(DEB_N));
  assign src       = {sleep_req && sleep_en, osc_fail_req && !osc_inh,
                      wdog_req && !wdog_inh, ext_req, 1'b0};
  assign any_src   = |src;
  assign first     = src & (~src + 5'd1);

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)
      deb_cnt <= '0;
    else if (deb_tick)
      deb_cnt <= !pin_match ? '0 : (deb_cnt == DW'(DEB_N)) ? deb_cnt : deb_cnt + 1'b1;
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      sys_cnt <= SW'(SYS_N);
      cpu_cnt <= CW'(CPU_N);
    end else if (any_src) begin
      sys_cnt <= SW'(SYS_N);
      cpu_cnt <= CW'(CPU_N);
    end else begin
      if (sys_cnt != '0) sys_cnt <= sys_cnt - 1'b1;
      if (cpu_cnt != '0) cpu_cnt <= cpu_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      opt_clr  <= 1'b1;
      sleep_en <= 1'b0;
      status   <= 5'b00001;
    end else begin
      opt_clr <= 1'b0;
      if (sleep_en_set) sleep_en <= 1'b1;
      if (any_src)      status <= first;
      else if (stat_we) status <= status & ~stat_wdata;
    end
  end

  assign sys_rst = (sys_cnt != '0);
  assign cpu_rst = (cpu_cnt != '0);
endmodule

module rst_seq_chk (
  input logic       clk,
  input logic       por_req,
  input logic       ext_req,
  input logic       wdog_req,
  input logic       wdog_inh,
  input logic       osc_fail_req,
  input logic       osc_inh,
  input logic       sleep_req,
  input logic       sleep_en,
  input logic       opt_clr,
  input logic       sys_rst,
  input logic       cpu_rst,
  input logic [4:0] status
);
  logic hw_src;
  assign hw_src = (wdog_req && !wdog_inh) || (osc_fail_req && !osc_inh) || (sleep_req && sleep_en);

  assert_src_resets_R1: assert property (@(posedge clk) disable iff (por_req)
    hw_src |=> (sys_rst && cpu_rst));
  assert_sys_hold_R2: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> !$past(hw_src || ext_req));
  assert_cpu_covers_R3: assert property (@(posedge clk) disable iff (por_req)
    sys_rst |-> cpu_rst);
  assert_sleep_keep_R5: assert property (@(posedge clk) disable iff (por_req)
    sleep_en |=> sleep_en);
  assert_optclr_low_R5: assert property (@(posedge clk) disable iff (por_req)
    !opt_clr |=> !opt_clr);
  assert_inhibit_R8: assert property (@(posedge clk) disable iff (por_req)
    (!sys_rst && wdog_inh && osc_inh && !ext_req && !(sleep_req && sleep_en)) |=> !sys_rst);
  assert_status_onehot_R10: assert property (@(posedge clk) disable iff (por_req)
    $onehot0(status));
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por_req(por_req), .ext_req(ext_req), .wdog_req(wdog_req),
  .wdog_inh(wdog_inh), .osc_fail_req(osc_fail_req), .osc_inh(osc_inh),
  .sleep_req(sleep_req), .sleep_en(sleep_en), .opt_clr(opt_clr),
  .sys_rst(sys_rst), .cpu_rst(cpu_rst), .status(status)
);

// File: tb/tb_rst_seq.sv
module tb_rst_seq;
  localparam int CLK = 10;
  localparam int SYS_N = 8, CPU_N = 32, DEB_N = 4;

  logic clk = 0, por_req = 1;
  logic [3:0] pin_in = 0, pin_mask = 0, pin_level = 0;
  logic pin_dis = 0, deb_tick = 0, wdog_req = 0, wdog_inh = 0, osc_fail_req = 0, osc_inh = 0;
  logic sleep_req = 0, sleep_en_set = 0, stat_we = 0;
  logic [4:0] stat_wdata = 0;
  logic opt_clr, sleep_en, sys_rst, cpu_rst;
  logic [4:0] status;
  int n_chk = 0, n_fail = 0;

  always #(CLK/2) clk = ~clk;

  rst_seq dut (.*);

  int m_sys, m_cpu, m_deb, m_flags, m_slp, m_opt;

  always @(posedge clk or posedge por_req) begin
    if (por_req) begin
      m_sys = SYS_N; m_cpu = CPU_N; m_deb = 0; m_flags = 1; m_slp = 0; m_opt = 1;
    end else begin
      bit match, ext, wd, os, sl;
      match = (pin_mask != 0) && (((pin_in ~^ pin_level) & pin_mask) == pin_mask);
      ext = (m_deb == DEB_N) && !pin_dis;
      wd = wdog_req && !wdog_inh;
      os = osc_fail_req && !osc_inh;
      sl = sleep_req && (m_slp == 1);
      if (deb_tick) m_deb = match ? ((m_deb < DEB_N) ? m_deb + 1 : m_deb) : 0;
      if (ext || wd || os || sl) begin
        m_sys = SYS_N; m_cpu = CPU_N;
        m_flags = ext ? 2 : wd ? 4 : os ? 8 : 16;
      end else begin
        if (m_sys > 0) m_sys--;
        if (m_cpu > 0) m_cpu--;
        if (stat_we) m_flags = m_flags & ~int'(stat_wdata);
      end
      if (sleep_en_set) m_slp = 1;
      m_opt = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK/4);
    chk("R2 sys_rst model", int'(sys_rst), int'(m_sys > 0));
    chk("R3 cpu_rst model", int'(cpu_rst), int'(m_cpu > 0));
    chk("R4 opt_clr model", int'(opt_clr), m_opt);
    chk("R5 sleep_en model", int'(sleep_en), m_slp);
    chk("R10 status model", int'(status), m_flags);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) deb_tick = 1;
    @(negedge clk) deb_tick = 0;
  endtask

  task automatic count_stretch(output int ns, output int nc);
    ns = 0; nc = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #(CLK/4);
      if (sys_rst) ns++;
      if (cpu_rst) nc++;
      if (i == 0) begin wdog_req = 0; osc_fail_req = 0; sleep_req = 0; end
    end
  endtask

  initial begin
    #(CLK*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ns, nc;
    cyc(2);
    chk("R4 por sys_rst", int'(sys_rst), 1);
    chk("R4 por opt_clr", int'(opt_clr), 1);
    chk("R4 por status", int'(status), 1);
    chk("R4 por sleep_en", int'(sleep_en), 0);
    por_req = 0;
    cyc(40);
    chk("R4 after por sys_rst", int'(sys_rst), 0);
    chk("R4 after por opt_clr", int'(opt_clr), 0);

    @(negedge clk) wdog_req = 1;
    count_stretch(ns, nc);
    chk("R2 sys length", ns, SYS_N);
    chk("R3 cpu length", nc, CPU_N);
    chk("R10 wdog flag", int'(status), 4);
    @(negedge clk) stat_we = 1; stat_wdata = 5'b00100;
    @(negedge clk) stat_we = 0;
    chk("R10 w1c", int'(status), 0);

    @(negedge clk) osc_fail_req = 1;
    count_stretch(ns, nc);
    chk("R1 osc sys", ns, SYS_N);
    chk("R10 osc flag", int'(status), 8);

    @(negedge clk) wdog_inh = 1; osc_inh = 1; wdog_req = 1; osc_fail_req = 1;
    count_stretch(ns, nc);
    chk("R8 inhibited sys", ns, 0);
    chk("R8 inhibited cpu", nc, 0);
    wdog_inh = 0; osc_inh = 0;

    @(negedge clk) sleep_req = 1;
    count_stretch(ns, nc);
    chk("R9 sleep disabled", ns, 0);
    @(negedge clk) sleep_en_set = 1;
    @(negedge clk) sleep_en_set = 0;
    chk("R9 sleep_en set", int'(sleep_en), 1);
    @(negedge clk) sleep_req = 1;
    count_stretch(ns, nc);
    chk("R1 sleep sys", ns, SYS_N);
    chk("R10 sleep flag", int'(status), 16);

    @(negedge clk) wdog_req = 1;
    count_stretch(ns, nc);
    chk("R5 sleep_en kept", int'(sleep_en), 1);
    chk("R5 opt_clr quiet", int'(opt_clr), 0);

    @(negedge clk) wdog_req = 1; osc_fail_req = 1;
    count_stretch(ns, nc);
    chk("R10 priority wdog over osc", int'(status), 4);

    @(negedge clk) wdog_req = 1;
    ns = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #(CLK/4);
      if (sys_rst) ns++;
      if (i == 0) wdog_req = 0;
      if (i == 4) osc_fail_req = 1;
      if (i == 5) osc_fail_req = 0;
    end
    chk("R11 restart sys", ns, 5 + SYS_N);

    pin_mask = 4'b0011; pin_level = 4'b0001; pin_in = 4'b1101;
    repeat (3) tick();
    cyc(3);
    chk("R7 three ticks no reset", int'(sys_rst), 0);
    pin_in = 4'b1111; tick();
    pin_in = 4'b1101; repeat (3) tick();
    cyc(3);
    chk("R7 restart after mismatch", int'(sys_rst), 0);
    tick();
    @(posedge clk); #(CLK/4);
    chk("R1 pin sys", int'(sys_rst), 1);
    chk("R1 pin cpu", int'(cpu_rst), 1);
    chk("R10 pin flag", int'(status), 2);
    @(negedge clk) pin_dis = 1;
    cyc(40);
    chk("R7 disabled", int'(sys_rst), 0);
    pin_dis = 0;
    pin_in = 4'b0000; tick();
    cyc(40);
    pin_mask = 4'b0000; pin_in = 4'b1111;
    repeat (6) tick();
    cyc(3);
    chk("R6 zero mask", int'(sys_rst), 0);
    pin_mask = 4'b1000; pin_level = 4'b1000; pin_in = 4'b1010;
    repeat (5) tick();
    cyc(1);
    chk("R6 masked match", int'(sys_rst), 1);
    pin_in = 4'b0000; tick();
    cyc(40);

    @(negedge clk) por_req = 1;
    #1;
    chk("R4 async sys_rst", int'(sys_rst), 1);
    chk("R4 async sleep_en", int'(sleep_en), 0);
    chk("R4 async status", int'(status), 1);
    cyc(2);
    por_req = 0;
    cyc(40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule